// File: doc/BRIEF.md
# Windowed DC and RMS Accumulator

This unit reduces a block of signed integer samples to four integer statistics: the DC mean, the sum of squares, the mean square and the RMS. Samples enter on a valid/ready stream. The block length is a power of two set at elaboration (`LOG2N`). The sample width `W` is 16, 24 or 32 bits. A `win_en` input selects whether each sample is first scaled by a fixed-point raised-cosine (Hanning) weight that depends on its position in the block.

After the last sample of a block is accepted, the unit forms the rounded mean and the rounded mean square. It then runs a bit-serial integer square root that produces one result bit per clock, rounds the root to the nearest integer, and publishes all four results together with a one-cycle `done` pulse. The stream stays stalled while this runs. For wide inputs the squares are shifted down before they are summed, so the square accumulator fits in 64 bits and can never wrap. The cost is that very small signals lose precision.

Top module: `dcrms_acc`

## Requirements
- R1: While and right after reset, `in_ready` is 1, `done` is 0 and every result output is 0.
- R2: With `win_en`=0, `dc_mean` equals floor((S + N/2) / N), where S is the sum of the block's N = 2^LOG2N samples. This is round-half-up, so a mean of -0.5 gives 0 and +0.5 gives 1.
- R3: When 2W-1+LOG2N <= 64, `sq_sum` is the exact sum of the squared (possibly weighted) samples.
- R4: `mean_sq` equals floor((`sq_sum` + N/2) / N).
- R5: `rms` is the integer nearest to the square root of `mean_sq`.
- R6: With `win_en`=1, the sample at position n (0 for the first sample of the block) is replaced by floor((x·c[n] + 16384) / 32768) before both accumulations. Here c[n] = round(32768 · 0.5 · (1 − cos(2πn/(N−1)))), an unsigned 16-bit value with 15 fraction bits.
- R7: Each square is shifted right, with truncation, by S = max(0, 2W−1+LOG2N−64) bits before accumulation. With W=32 and LOG2N=4, a block of −2^31 gives `sq_sum` = 2^63 with no wrap, and a block of 2 gives `sq_sum` = 0.
- R8: `in_ready` drops in the cycle after the last sample of a block is accepted and stays low until `done`. No sample is accepted while `in_ready` is low.
- R9: `done` is a single-cycle pulse. It is asserted at the 33rd rising edge after the edge that accepted the last sample.
- R10: The result outputs change only in the cycle in which `done` is high. Between blocks and during the next block they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Apply position-dependent Hanning weight to each accepted sample |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Unit accepts a sample this cycle |
| in_data | input | W | Signed sample |
| done | output | 1 | One-cycle pulse: new results published |
| dc_mean | output | W | Rounded signed mean |
| sq_sum | output | 64 | Sum of (downscaled) squares |
| mean_sq | output | 64 | Rounded mean square |
| rms | output | 32 | Rounded square root of `mean_sq` |

## Verification
The embedded properties assume that reset is synchronous and is held across at least one edge. They also assume that `in_data` matters only when `in_valid` and `in_ready` are both high, so the monotonic growth of the square accumulator is only checked on accepted samples. The bench keeps `win_en` constant for a whole block and changes it only between blocks, because the rounding model weights every sample with one setting. It drives inputs on falling edges and inserts idle gaps inside some blocks, so the stall path is exercised. Sample values stay within the signed W-bit range, including the most negative value.

// File: rtl/dcrms_acc.sv
module dcrms_acc #(
  parameter int W     = 16,
  parameter int LOG2N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                win_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_data,
  output logic                done,
  output logic signed [W-1:0] dc_mean,
  output logic [63:0]         sq_sum,
  output logic [63:0]         mean_sq,
  output logic [31:0]         rms
);

  localparam int N     = 1 << LOG2N;
  localparam int SW    = W + LOG2N;
  localparam int NEED  = 2 * W - 1 + LOG2N;
  localparam int SQ_SH = (NEED > 64) ? NEED - 64 : 0;
  localparam int PW    = W + 17;

  typedef enum logic [1:0] {S_ACC, S_LOAD, S_ROOT} st_t;

  function automatic logic [15:0] hann_q15(input int n);
    longint pi_q30, x, x2, term, s, w;
    int m;
    pi_q30 = 64'sd3373259426;
    m = (n < N - 1 - n) ? n : N - 1 - n;
    x = (pi_q30 * m) / (N - 1);
    x2 = (x * x) >>> 30;
    term = x;
    s = x;
    for (int k = 1; k <= 6; k++) begin
      term = -((term * x2) >>> 30) / ((2 * k) * (2 * k + 1));
      s = s + term;
    end
    w = (s * s) >>> 30;
    return 16'((w + 64'sd16384) >>> 15);
  endfunction

  logic [15:0] win_rom [N];
  for (genvar g = 0; g < N; g++) begin : g_win
    assign win_rom[g] = hann_q15(g);
  end

  st_t                 st;
  logic [LOG2N-1:0]    cnt;
  logic signed [SW-1:0] sum_acc;
  logic [63:0]         sq_acc;
  logic [63:0]         op;
  logic [33:0]         rem;
  logic [31:0]         root;
  logic [4:0]          it;
  logic signed [W-1:0] pend_mean;
  logic [63:0]         pend_sq, pend_msq;

  assign in_ready = (st == S_ACC);

  logic signed [PW-1:0] prod, prnd;
  logic signed [W-1:0]  ws;
  logic signed [2*W-1:0] sq;
  logic [63:0]          sq_add;
  assign prod   = PW'(in_data) * PW'($signed({1'b0, win_rom[cnt]}));
  assign prnd   = prod + PW'(16384);
  assign ws     = win_en ? W'(prnd >>> 15) : in_data;
  assign sq     = (2*W)'(ws) * (2*W)'(ws);
  assign sq_add = 64'($unsigned(sq) >> SQ_SH);

  logic signed [SW:0]  msum;
  logic signed [W-1:0] mean_c;
  logic [64:0]         mtmp;
  logic [63:0]         msq_c;
  assign msum   = {sum_acc[SW-1], sum_acc} + (SW+1)'(N / 2);
  assign mean_c = W'(msum >>> LOG2N);
  assign mtmp   = {1'b0, sq_acc} + 65'(N / 2);
  assign msq_c  = 64'(mtmp >> LOG2N);

  logic [35:0] rem_n, trial, rem_nx;
  logic        ge;
  logic [31:0] root_nx, rms_c;
  assign rem_n   = {rem, op[63:62]};
  assign trial   = {2'b00, root, 2'b01};
  assign ge      = rem_n >= trial;
  assign rem_nx  = ge ? rem_n - trial : rem_n;
  assign root_nx = {root[30:0], ge};
  assign rms_c   = root_nx + 32'(rem_nx > {4'b0, root_nx});

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_ACC;  cnt <= '0;  sum_acc <= '0;  sq_acc <= '0;
      op <= '0;  rem <= '0;  root <= '0;  it <= '0;
      pend_mean <= '0;  pend_sq <= '0;  pend_msq <= '0;
      done <= 1'b0;  dc_mean <= '0;  sq_sum <= '0;  mean_sq <= '0;  rms <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_ACC: if (in_valid) begin
          cnt     <= cnt + 1'b1;
          sum_acc <= sum_acc + {{LOG2N{ws[W-1]}}, ws};
          sq_acc  <= sq_acc + sq_add;
          if (&cnt) st <= S_LOAD;
        end
        S_LOAD: begin
          op <= msq_c;  pend_mean <= mean_c;  pend_sq <= sq_acc;  pend_msq <= msq_c;
          sum_acc <= '0;  sq_acc <= '0;  rem <= '0;  root <= '0;  it <= '0;
          st <= S_ROOT;
        end
        S_ROOT: begin
          op   <= op << 2;
          rem  <= rem_nx[33:0];
          root <= root_nx;
          it   <= it + 1'b1;
          if (it == 5'd31) begin
            done <= 1'b1;  dc_mean <= pend_mean;  sq_sum <= pend_sq;
            mean_sq <= pend_msq;  rms <= rms_c;  st <= S_ACC;
          end
        end
        default: st <= S_ACC;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_stall_after_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (&cnt)) |=> !in_ready);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (sq_acc >= $past(sq_acc)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !($stable(rms) && $stable(dc_mean) && $stable(sq_sum) && $stable(mean_sq)) |-> done);

  a_r5_round_root: assert property (@(posedge clk) disable iff (rst)
    done |-> ((72'(rms) * 72'(rms) <= 72'(mean_sq) + 72'(rms)) &&
              (72'(mean_sq) <= 72'(rms) * 72'(rms) + 72'(rms))));

endmodule

// File: tb/dcrms_acc_tb.sv
`timescale 1ns/1ps
module dcrms_acc_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, win_en;
  logic v16, r16, dn16, v32, r32, dn32;
  logic signed [15:0] d16, m16;
  logic signed [31:0] d32, m32;
  logic [63:0] s16, q16, s32, q32;
  logic [31:0] rt16, rt32;

  dcrms_acc #(.W(16), .LOG2N(4)) u_dut (
    .clk(clk), .rst(rst), .win_en(win_en), .in_valid(v16), .in_ready(r16),
    .in_data(d16), .done(dn16), .dc_mean(m16), .sq_sum(s16), .mean_sq(q16), .rms(rt16));

  dcrms_acc #(.W(32), .LOG2N(4)) u_dut_w32 (
    .clk(clk), .rst(rst), .win_en(win_en), .in_valid(v32), .in_ready(r32),
    .in_data(d32), .done(dn32), .dc_mean(m32), .sq_sum(s32), .mean_sq(q32), .rms(rt32));

  typedef struct packed {
    logic        win;
    logic [1:0]  kind;
    logic [31:0] amp;
    logic [31:0] off;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b0, 2'd0, 32'sd1000,   32'sd0},
    '{1'b0, 2'd1, 32'sd300,    32'sd50},
    '{1'b0, 2'd2, 32'sd100,    -32'sd800},
    '{1'b0, 2'd3, 32'sd8,      32'sd0},
    '{1'b0, 2'd3, -32'sd8,     32'sd0},
    '{1'b0, 2'd0, -32'sd32768, 32'sd0},
    '{1'b1, 2'd0, 32'sd20000,  32'sd0},
    '{1'b1, 2'd1, 32'sd10000,  32'sd0},
    '{1'b1, 2'd2, 32'sd2000,   -32'sd15000},
    '{1'b0, 2'd0, 32'sd32767,  32'sd0}
  };

  int checks = 0, errors = 0;
  bit fin = 1'b0;
  longint smp [16];
  logic [63:0] e_mean, e_sq, e_msq, e_rms;
  logic [63:0] p_mean [2], p_sq [2], p_msq [2], p_rms [2];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(input int sh, input bit win);
    longint sum, x, c, msq, r;
    logic [127:0] ss;
    sum = 0; ss = '0;
    for (int i = 0; i < 16; i++) begin
      x = smp[i];
      if (win) begin
        c = longint'(32768.0 * 0.5 * (1.0 - $cos(2.0 * 3.14159265358979 * i / 15.0)));
        x = (x * c + 16384) >>> 15;
      end
      sum = sum + x;
      ss = ss + (128'(x * x) >> sh);
    end
    e_mean = 64'((sum + 8) >>> 4);
    e_sq   = ss[63:0];
    msq    = longint'((ss + 128'd8) >> 4);
    e_msq  = 64'(msq);
    r = longint'($sqrt(real'(msq)));
    while (r * r > msq) r--;
    while ((r + 1) * (r + 1) <= msq) r++;
    if (msq - r * r > r) r++;
    e_rms = 64'(r);
  endtask

  task automatic rd(input bit sel, output logic [63:0] mn, output logic [63:0] sq,
                    output logic [63:0] mq, output logic [63:0] rt);
    mn = sel ? 64'(m32) : 64'(m16);
    sq = sel ? s32 : s16;
    mq = sel ? q32 : q16;
    rt = sel ? 64'(rt32) : 64'(rt16);
  endtask

  task automatic run(input bit sel, input bit win, input bit gaps, input string rm, input string rs);
    logic [63:0] a_mn, a_sq, a_mq, a_rt;
    int lat;
    bit hold_ok;
    model(sel ? 3 : 0, win);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      win_en = win;
      if (gaps && (i % 5 == 2)) begin
        v16 = 1'b0; v32 = 1'b0;
        @(negedge clk);
      end
      if (sel) begin v32 = 1'b1; d32 = 32'(smp[i]); end
      else     begin v16 = 1'b1; d16 = 16'(smp[i]); end
      @(posedge clk);
    end
    @(negedge clk);
    v16 = 1'b0; v32 = 1'b0;
    chk("R8", "ready after last", 64'(sel ? r32 : r16), 64'd0);
    lat = 0; hold_ok = 1'b1;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      rd(sel, a_mn, a_sq, a_mq, a_rt);
      if (!(sel ? dn32 : dn16) && (a_mn !== p_mean[sel] || a_sq !== p_sq[sel] ||
          a_mq !== p_msq[sel] || a_rt !== p_rt_get(sel))) hold_ok = 1'b0;
      if (!(sel ? dn32 : dn16) && !(sel ? r32 : r16) == 1'b0) hold_ok = 1'b0;
    end while (!(sel ? dn32 : dn16) && lat < 100);
    chk("R9", "done latency", 64'(lat), 64'd33);
    chk("R10", "hold before done", 64'(hold_ok), 64'd1);
    rd(sel, a_mn, a_sq, a_mq, a_rt);
    chk(rm, "mean", a_mn, e_mean);
    chk(rs, "square sum", a_sq, e_sq);
    chk("R4", "mean square", a_mq, e_msq);
    chk("R5", "rms", a_rt, e_rms);
    @(negedge clk);
    chk("R9", "done single cycle", 64'(sel ? dn32 : dn16), 64'd0);
    chk("R8", "ready after done", 64'(sel ? r32 : r16), 64'd1);
    p_mean[sel] = a_mn; p_sq[sel] = a_sq; p_msq[sel] = a_mq; p_rms[sel] = a_rt;
    repeat (3) @(negedge clk);
    rd(sel, a_mn, a_sq, a_mq, a_rt);
    chk("R10", "hold when idle", 64'(a_rt == p_rms[sel] && a_mn == p_mean[sel]), 64'd1);
  endtask

  function automatic logic [63:0] p_rt_get(input bit sel);
    return p_rms[sel];
  endfunction

  initial begin
    #(8 * 150000);
    if (!fin) begin
      errors++;
      $display("FAIL R9 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; win_en = 1'b0; v16 = 1'b0; v32 = 1'b0; d16 = '0; d32 = '0;
    for (int k = 0; k < 2; k++) begin p_mean[k] = 0; p_sq[k] = 0; p_msq[k] = 0; p_rms[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready in reset", 64'(r16), 64'd1);
    chk("R1", "done in reset", 64'(dn16), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", 64'(r32), 64'd1);
    chk("R1", "done after reset", 64'(dn32), 64'd0);
    chk("R1", "results after reset", {m16 == 0, s16 == 0, q16 == 0, rt16 == 0, rt32 == 0}, 64'd31);

    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < 16; i++) begin
        longint a, o;
        a = longint'($signed(TBL[t].amp));
        o = longint'($signed(TBL[t].off));
        case (TBL[t].kind)
          2'd0: smp[i] = a;
          2'd1: smp[i] = ((i % 2) ? -a : a) + o;
          2'd2: smp[i] = a * i + o;
          default: smp[i] = (i == 0) ? a : 0;
        endcase
      end
      if (TBL[t].win) run(1'b0, 1'b1, t[0], "R6", "R6");
      else            run(1'b0, 1'b0, t[0], "R2", "R3");
    end

    for (int i = 0; i < 16; i++) smp[i] = -64'sd2147483648;
    run(1'b1, 1'b0, 1'b0, "R2", "R7");
    chk("R7", "full-scale square sum", s32, 64'h8000_0000_0000_0000);
    for (int i = 0; i < 16; i++) smp[i] = 2;
    run(1'b1, 1'b0, 1'b1, "R2", "R7");
    chk("R7", "small-signal underflow", s32, 64'd0);
    for (int i = 0; i < 16; i++) smp[i] = (i % 2) ? -64'sd2147483647 : 64'sd2147483647;
    run(1'b1, 1'b1, 1'b0, "R6", "R7");

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule